// File: doc/BRIEF.md
# Hardware Monitor Limit Comparator

This block watches fan tachometer period counts and temperature readings and raises sticky alarm bits when a reading crosses its programmed limit. Each fan has a 16-bit minimum-speed limit; since a slow fan produces a long period count, a fan alarm means the count has risen above its limit. Each temperature channel has a signed 8-bit high limit in degrees Celsius. A host programs the limits and services the alarm bits over a byte-wide register bus with a combinational read port.

Readings are compared only when the sensor front end pulses `sample_vld`. A fan's comparison is suppressed while its PWM output is disabled or its duty byte is zero, because a stopped fan would otherwise alarm on every sample. Alarm bits stay set until the host writes a one to them. The `irq` output is high while any alarm bit is set.

Top module: `hwmon_limit_cmp`

## Requirements
- R1: After reset every tachometer limit byte reads FFh, every temperature high limit reads 7Fh (+127), both status registers read 00h and `irq` is low.
- R2: The high byte of fan f's limit is at address 54h+f and the low byte is at 58h+f. A low-byte write is staged and does not change the limit in use or the value read back. A high-byte write loads the limit in use with {written byte, staged low byte}, and both addresses then read back the new limit.
- R3: On a sample, the fan status bit f (bit f of the fan status register at 42h) is set when fan f's period count is strictly greater than its 16-bit limit. An equal count does not set it.
- R4: A fan's status bit is not set while that fan's PWM duty byte is 00h.
- R5: A fan's status bit is not set while that fan's PWM enable input is low. On the first sample after the mask lifts, the bit is set only if the count exceeds the limit at that sample.
- R6: Temperature channel c has its high limit at 60h+c. On a sample, bit 4+c of the temperature status register at 41h is set when the reading is strictly greater than the limit, both taken as 8-bit two's complement values.
- R7: No status bit is set in a cycle without `sample_vld`, whatever the readings are.
- R8: Status bits are sticky. Writing to 41h or 42h clears each bit written as 1 and leaves bits written as 0 untouched. If a sample sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: While `lock_i` is high, writes to the temperature limits are ignored. Writes to the tachometer limits are still accepted.
- R10: `irq` is high exactly when at least one fan or temperature status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| lock_i | input | 1 | Write-protects the temperature limits |
| sample_vld | input | 1 | New readings are valid this cycle |
| tach_count | input | NUM_FANS*16 | Period counts, fan f in bits [16f+15:16f] |
| pwm_duty | input | NUM_FANS*8 | Current duty byte, fan f in bits [8f+7:8f] |
| pwm_en | input | NUM_FANS | PWM enable per fan |
| temp_rd | input | NUM_TEMPS*8 | Signed temperature readings, channel c in bits [8c+7:8c] |
| fan_sts | output | NUM_FANS | Fan alarm bits |
| temp_sts | output | NUM_TEMPS | Temperature alarm bits |
| irq | output | 1 | Any alarm bit set |

## Verification
The assertions watch on every cycle that an alarm bit only rises after a sample, that a fan bit only rises after an unmasked sample, that a set bit survives any cycle without a matching clear, and that the limits change only through a high-byte write or an unlocked temperature write. What they cannot show is whether the comparison itself is right: strict versus equal, signed versus unsigned order, the staged low byte, and the set-over-clear priority are shown only by the bench scenarios, which compare the status outputs against a model of the requirements.

// File: rtl/hwmon_lim_pkg.sv
package hwmon_lim_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 4;

    localparam logic [BYTE_W-1:0] ADDR_STS_TEMP     = 8'h41;
    localparam logic [BYTE_W-1:0] ADDR_STS_FAN      = 8'h42;
    localparam logic [BYTE_W-1:0] ADDR_TACH_HI_BASE = 8'h54;
    localparam logic [BYTE_W-1:0] ADDR_TACH_LO_BASE = 8'h58;
    localparam logic [BYTE_W-1:0] ADDR_TEMP_LIM_BASE = 8'h60;

    // remote channel 0 lands on bit 4 of the temperature status register
    localparam int TEMP_STS_LSB = 4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TACH_LO,
        ACC_TACH_HI,
        ACC_TEMP_LIM,
        ACC_STS_TEMP,
        ACC_STS_FAN
    } acc_kind_e;

endpackage

// File: rtl/hwmon_reg_dec.sv
module hwmon_reg_dec
    import hwmon_lim_pkg::*;
#(
    parameter int NUM_FANS  = 4,
    parameter int NUM_TEMPS = 3
) (
    input  logic [BYTE_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [BYTE_W-1:0] off_hi, off_lo, off_tl;

    always_comb begin
        off_hi = addr - ADDR_TACH_HI_BASE;
        off_lo = addr - ADDR_TACH_LO_BASE;
        off_tl = addr - ADDR_TEMP_LIM_BASE;
        kind   = ACC_NONE;
        idx    = '0;
        if (addr == ADDR_STS_TEMP) begin
            kind = ACC_STS_TEMP;
        end else if (addr == ADDR_STS_FAN) begin
            kind = ACC_STS_FAN;
        end else if (addr >= ADDR_TACH_HI_BASE && int'(off_hi) < NUM_FANS) begin
            kind = ACC_TACH_HI;
            idx  = off_hi[IDX_W-1:0];
        end else if (addr >= ADDR_TACH_LO_BASE && int'(off_lo) < NUM_FANS) begin
            kind = ACC_TACH_LO;
            idx  = off_lo[IDX_W-1:0];
        end else if (addr >= ADDR_TEMP_LIM_BASE && int'(off_tl) < NUM_TEMPS) begin
            kind = ACC_TEMP_LIM;
            idx  = off_tl[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/hwmon_tach_chan.sv
module hwmon_tach_chan
    import hwmon_lim_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr,
    input  logic              sample_vld,
    input  logic [CNT_W-1:0]  count,
    input  logic [DUTY_W-1:0] duty,
    input  logic              pwm_en,
    output logic [CNT_W-1:0]  limit,
    output logic              sts
);
    localparam int HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo_stage;
        logic [CNT_W-1:0]  limit;
        logic              sts;
    } tach_st_t;

    tach_st_t s_d, s_q;
    logic     armed_d, hit_d;

    always_comb begin
        s_d     = s_q;
        armed_d = pwm_en && (duty != '0);
        hit_d   = sample_vld && armed_d && (count > s_q.limit);
        if (lo_we) s_d.lo_stage = wdata;
        if (hi_we) s_d.limit    = {wdata[HI_W-1:0], s_q.lo_stage};
        if (clr)   s_d.sts      = 1'b0;
        if (hit_d) s_d.sts      = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lo_stage <= '1;
            s_q.limit    <= '1;
            s_q.sts      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign limit = s_q.limit;
    assign sts   = s_q.sts;
endmodule

// File: rtl/hwmon_temp_chan.sv
module hwmon_temp_chan
    import hwmon_lim_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr,
    input  logic              sample_vld,
    input  logic [TEMP_W-1:0] reading,
    output logic [TEMP_W-1:0] limit,
    output logic              sts
);
    localparam logic [TEMP_W-1:0] LIM_RST = {1'b0, {(TEMP_W-1){1'b1}}};

    typedef struct packed {
        logic [TEMP_W-1:0] limit;
        logic              sts;
    } temp_st_t;

    temp_st_t s_d, s_q;
    logic     hit_d;

    always_comb begin
        s_d   = s_q;
        hit_d = sample_vld && ($signed(reading) > $signed(s_q.limit));
        if (lim_we) s_d.limit = wdata[TEMP_W-1:0];
        if (clr)    s_d.sts   = 1'b0;
        if (hit_d)  s_d.sts   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.limit <= LIM_RST;
            s_q.sts   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign limit = s_q.limit;
    assign sts   = s_q.sts;
endmodule

// File: rtl/hwmon_limit_cmp.sv
module hwmon_limit_cmp
    import hwmon_lim_pkg::*;
#(
    parameter int NUM_FANS  = 4,
    parameter int NUM_TEMPS = 3,
    parameter int CNT_W     = 16,
    parameter int DUTY_W    = 8,
    parameter int TEMP_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_en,
    input  logic [BYTE_W-1:0]           reg_addr,
    input  logic [BYTE_W-1:0]           reg_wdata,
    output logic [BYTE_W-1:0]           reg_rdata,
    input  logic                        lock_i,
    input  logic                        sample_vld,
    input  logic [NUM_FANS*CNT_W-1:0]   tach_count,
    input  logic [NUM_FANS*DUTY_W-1:0]  pwm_duty,
    input  logic [NUM_FANS-1:0]         pwm_en,
    input  logic [NUM_TEMPS*TEMP_W-1:0] temp_rd,
    output logic [NUM_FANS-1:0]         fan_sts,
    output logic [NUM_TEMPS-1:0]        temp_sts,
    output logic                        irq
);
    acc_kind_e                   acc_kind;
    logic [IDX_W-1:0]            acc_idx;
    logic [NUM_FANS*CNT_W-1:0]   tach_lim_flat;
    logic [NUM_TEMPS*TEMP_W-1:0] temp_lim_flat;

    hwmon_reg_dec #(.NUM_FANS(NUM_FANS), .NUM_TEMPS(NUM_TEMPS)) u_dec (
        .addr (reg_addr),
        .kind (acc_kind),
        .idx  (acc_idx)
    );

    for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
        logic lo_we_w, hi_we_w, clr_w;
        assign lo_we_w = reg_wr_en && acc_kind == ACC_TACH_LO && int'(acc_idx) == f;
        assign hi_we_w = reg_wr_en && acc_kind == ACC_TACH_HI && int'(acc_idx) == f;
        assign clr_w   = reg_wr_en && acc_kind == ACC_STS_FAN && reg_wdata[f];

        hwmon_tach_chan #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_tach (
            .clk        (clk),
            .rst_n      (rst_n),
            .lo_we      (lo_we_w),
            .hi_we      (hi_we_w),
            .wdata      (reg_wdata),
            .clr        (clr_w),
            .sample_vld (sample_vld),
            .count      (tach_count[f*CNT_W +: CNT_W]),
            .duty       (pwm_duty[f*DUTY_W +: DUTY_W]),
            .pwm_en     (pwm_en[f]),
            .limit      (tach_lim_flat[f*CNT_W +: CNT_W]),
            .sts        (fan_sts[f])
        );
    end

    for (genvar c = 0; c < NUM_TEMPS; c++) begin : g_temp
        logic lim_we_w, clr_w;
        assign lim_we_w = reg_wr_en && !lock_i && acc_kind == ACC_TEMP_LIM
                          && int'(acc_idx) == c;
        assign clr_w    = reg_wr_en && acc_kind == ACC_STS_TEMP
                          && reg_wdata[TEMP_STS_LSB + c];

        hwmon_temp_chan #(.TEMP_W(TEMP_W)) u_temp (
            .clk        (clk),
            .rst_n      (rst_n),
            .lim_we     (lim_we_w),
            .wdata      (reg_wdata),
            .clr        (clr_w),
            .sample_vld (sample_vld),
            .reading    (temp_rd[c*TEMP_W +: TEMP_W]),
            .limit      (temp_lim_flat[c*TEMP_W +: TEMP_W]),
            .sts        (temp_sts[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        unique case (acc_kind)
            ACC_TACH_LO:  reg_rdata = tach_lim_flat[int'(acc_idx)*CNT_W +: BYTE_W];
            ACC_TACH_HI:  reg_rdata = tach_lim_flat[int'(acc_idx)*CNT_W + BYTE_W +: BYTE_W];
            ACC_TEMP_LIM: reg_rdata = temp_lim_flat[int'(acc_idx)*TEMP_W +: TEMP_W];
            ACC_STS_FAN:  reg_rdata[NUM_FANS-1:0] = fan_sts;
            ACC_STS_TEMP: reg_rdata[TEMP_STS_LSB +: NUM_TEMPS] = temp_sts;
            default:      reg_rdata = '0;
        endcase
    end

    assign irq = (|fan_sts) || (|temp_sts);
endmodule

// File: rtl/hwmon_limit_cmp_chk.sv
module hwmon_limit_cmp_chk
    import hwmon_lim_pkg::*;
#(
    parameter int NUM_FANS  = 4,
    parameter int NUM_TEMPS = 3,
    parameter int CNT_W     = 16,
    parameter int DUTY_W    = 8,
    parameter int TEMP_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr_en,
    input logic [BYTE_W-1:0]           reg_addr,
    input logic [BYTE_W-1:0]           reg_wdata,
    input logic                        lock_i,
    input logic                        sample_vld,
    input logic [NUM_FANS*DUTY_W-1:0]  pwm_duty,
    input logic [NUM_FANS-1:0]         pwm_en,
    input logic [NUM_FANS-1:0]         fan_sts,
    input logic [NUM_TEMPS-1:0]        temp_sts,
    input logic                        irq,
    input logic [NUM_FANS*CNT_W-1:0]   tach_lim_flat,
    input logic [NUM_TEMPS*TEMP_W-1:0] temp_lim_flat
);
    for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan_chk
        assert_fan_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fan_sts[f] && !(reg_wr_en && reg_addr == ADDR_STS_FAN && reg_wdata[f])
            |=> fan_sts[f]);

        assert_fan_masked_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fan_sts[f]) |->
            $past(sample_vld && pwm_en[f] && (pwm_duty[f*DUTY_W +: DUTY_W] != '0)));

        assert_tach_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(tach_lim_flat[f*CNT_W +: CNT_W]) |->
            $past(reg_wr_en && reg_addr == ADDR_TACH_HI_BASE + BYTE_W'(f)));
    end

    for (genvar c = 0; c < NUM_TEMPS; c++) begin : g_temp_chk
        assert_temp_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(temp_sts[c]) |-> $past(sample_vld));

        assert_temp_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(temp_lim_flat[c*TEMP_W +: TEMP_W]) |->
            $past(reg_wr_en && !lock_i && reg_addr == ADDR_TEMP_LIM_BASE + BYTE_W'(c)));
    end

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_vld));
endmodule

bind hwmon_limit_cmp hwmon_limit_cmp_chk #(
    .NUM_FANS (NUM_FANS),
    .NUM_TEMPS(NUM_TEMPS),
    .CNT_W    (CNT_W),
    .DUTY_W   (DUTY_W),
    .TEMP_W   (TEMP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .lock_i        (lock_i),
    .sample_vld    (sample_vld),
    .pwm_duty      (pwm_duty),
    .pwm_en        (pwm_en),
    .fan_sts       (fan_sts),
    .temp_sts      (temp_sts),
    .irq           (irq),
    .tach_lim_flat (tach_lim_flat),
    .temp_lim_flat (temp_lim_flat)
);

// File: tb/hwmon_limit_cmp_test.sv
`timescale 1ns/1ps
module hwmon_limit_cmp_test;
    localparam int NF = 4;
    localparam int NT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          lock_i = 1'b0;
    logic          sample_vld = 1'b0;
    logic [15:0]   tach [NF];
    logic [7:0]    duty [NF];
    logic [NF-1:0] pwm_en = '1;
    logic [7:0]    temp [NT];
    logic [NF*16-1:0] tach_count;
    logic [NF*8-1:0]  pwm_duty;
    logic [NT*8-1:0]  temp_rd;
    logic [NF-1:0] fan_sts;
    logic [NT-1:0] temp_sts;
    logic          irq;

    for (genvar i = 0; i < NF; i++) begin : g_pack_f
        assign tach_count[i*16 +: 16] = tach[i];
        assign pwm_duty[i*8 +: 8]     = duty[i];
    end
    for (genvar i = 0; i < NT; i++) begin : g_pack_t
        assign temp_rd[i*8 +: 8] = temp[i];
    end

    hwmon_limit_cmp uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_i(lock_i),
        .sample_vld(sample_vld), .tach_count(tach_count), .pwm_duty(pwm_duty),
        .pwm_en(pwm_en), .temp_rd(temp_rd), .fan_sts(fan_sts),
        .temp_sts(temp_sts), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            due;
        logic [NF-1:0] fan;
        logic [NT-1:0] tmp;
        string         tag;
    } exp_t;
    exp_t q [$];

    // requirement model
    logic [15:0]   m_lim   [NF];
    logic [7:0]    m_stage [NF];
    logic [7:0]    m_tlim  [NT];
    logic [NF-1:0] m_fsts;
    logic [NT-1:0] m_tsts;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one bus/sample cycle, started just after a falling edge
    task automatic step(bit w, logic [7:0] a, logic [7:0] d, bit s, string tag);
        logic [NF-1:0] fh;
        logic [NT-1:0] th;
        exp_t e;
        fh = '0; th = '0;
        if (s) begin
            for (int f = 0; f < NF; f++)
                fh[f] = pwm_en[f] && duty[f] != 8'h00 && tach[f] > m_lim[f];
            for (int c = 0; c < NT; c++)
                th[c] = $signed(temp[c]) > $signed(m_tlim[c]);
        end
        if (w) begin
            if (a >= 8'h58 && a < 8'h58 + NF) m_stage[a - 8'h58] = d;
            else if (a >= 8'h54 && a < 8'h54 + NF) m_lim[a - 8'h54] = {d, m_stage[a - 8'h54]};
            else if (a >= 8'h60 && a < 8'h60 + NT) begin
                if (!lock_i) m_tlim[a - 8'h60] = d;
            end
            else if (a == 8'h41) m_tsts = m_tsts & ~d[4 +: NT];
            else if (a == 8'h42) m_fsts = m_fsts & ~d[NF-1:0];
        end
        m_fsts = m_fsts | fh;
        m_tsts = m_tsts | th;
        e.due = cyc + 1; e.fan = m_fsts; e.tmp = m_tsts; e.tag = tag;
        q.push_back(e);
        reg_wr_en = w; reg_addr = a; reg_wdata = d; sample_vld = s;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; sample_vld = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic smp(string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, tag);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        check(tag, 32'(reg_rdata), 32'(exp));
    endtask

    // monitor: compares status outputs as the design produces them
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " fan_sts"}, 32'(fan_sts), 32'(e.fan));
                check({e.tag, " temp_sts"}, 32'(temp_sts), 32'(e.tmp));
                check({e.tag, " irq R10"}, 32'(irq), 32'((|e.fan) || (|e.tmp)));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin
            tach[i] = '0; duty[i] = 8'h80; m_lim[i] = 16'hFFFF; m_stage[i] = 8'hFF;
        end
        for (int i = 0; i < NT; i++) begin
            temp[i] = 8'h00; m_tlim[i] = 8'h7F;
        end
        m_fsts = '0; m_tsts = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h54, 8'hFF, "R1 tach hi reset");
        rd(8'h5B, 8'hFF, "R1 tach lo reset");
        rd(8'h60, 8'h7F, "R1 temp limit reset");
        rd(8'h41, 8'h00, "R1 temp status reset");
        rd(8'h42, 8'h00, "R1 fan status reset");
        check("R1 irq reset", 32'(irq), 32'h0);

        // R2 staged low byte, R3 strict compare
        wr(8'h58, 8'hE8, "R2 lo write");
        rd(8'h58, 8'hFF, "R2 lo staged not visible");
        tach[0] = 16'h0400;
        smp("R2 half update not compared");
        wr(8'h54, 8'h03, "R2 hi commit");
        rd(8'h54, 8'h03, "R2 hi readback");
        rd(8'h58, 8'hE8, "R2 lo readback after commit");
        tach[0] = 16'd1000;
        smp("R3 equal no alarm");
        tach[0] = 16'd1001;
        smp("R3 greater sets");
        rd(8'h42, 8'h01, "R3 fan status reg");

        // R8 sticky and W1C
        tach[0] = 16'd0;
        smp("R8 sticky after low reading");
        wr(8'h42, 8'h00, "R8 zero write no effect");
        wr(8'h42, 8'h01, "R8 write one clears");
        rd(8'h42, 8'h00, "R8 cleared readback");

        // R7 no sample, no alarm
        tach[0] = 16'd2000;
        temp[0] = 8'h7F;
        repeat (4) @(negedge clk);
        rd(8'h42, 8'h00, "R7 fan idle without sample");
        check("R7 temp idle without sample", 32'(temp_sts), 32'h0);
        temp[0] = 8'h00;
        step(1'b1, 8'h42, 8'h01, 1'b1, "R8 set wins over clear");
        tach[0] = 16'd0;
        wr(8'h42, 8'h01, "R8 clear fan0");

        // R4 / R5 masking on fan 1
        wr(8'h59, 8'h64, "R2 fan1 lo");
        wr(8'h55, 8'h00, "R2 fan1 hi");
        tach[1] = 16'd500; duty[1] = 8'h00;
        smp("R4 zero duty masks");
        duty[1] = 8'h80; pwm_en[1] = 1'b0;
        smp("R5 disabled masks");
        pwm_en[1] = 1'b1; tach[1] = 16'd50;
        smp("R5 unmask below limit");
        tach[1] = 16'd500;
        smp("R5 unmask above limit sets");
        tach[1] = 16'd0;
        wr(8'h42, 8'h02, "R8 clear fan1");

        // R6 signed temperature compare
        wr(8'h60, 8'h32, "R6 limit +50");
        temp[0] = 8'hCE;
        smp("R6 -50 below +50");
        temp[0] = 8'h32;
        smp("R6 equal no alarm");
        temp[0] = 8'h33;
        smp("R6 +51 sets");
        rd(8'h41, 8'h10, "R6 bit4 for channel0");
        temp[0] = 8'h80;
        wr(8'h41, 8'h10, "R8 clear temp0");
        wr(8'h61, 8'hCE, "R6 limit -50");
        temp[1] = 8'hCD;
        smp("R6 -51 below -50");
        temp[1] = 8'h05;
        smp("R6 +5 above -50 signed");
        rd(8'h41, 8'h20, "R6 bit5 for channel1");
        temp[1] = 8'h80;
        wr(8'h41, 8'h20, "R8 clear temp1");

        // R9 lock
        lock_i = 1'b1;
        wr(8'h62, 8'h00, "R9 locked temp write");
        rd(8'h62, 8'h7F, "R9 temp limit unchanged");
        wr(8'h5B, 8'h10, "R9 tach lo under lock");
        wr(8'h57, 8'h00, "R9 tach hi under lock");
        rd(8'h5B, 8'h10, "R9 tach lo accepted");
        rd(8'h57, 8'h00, "R9 tach hi accepted");
        tach[3] = 16'd17;
        smp("R9 new tach limit used");
        lock_i = 1'b0;
        tach[3] = 16'd0;
        wr(8'h62, 8'h00, "R9 unlocked temp write");
        rd(8'h62, 8'h00, "R9 temp limit written");
        temp[2] = 8'h01;
        smp("R6 channel2 sets bit6");
        rd(8'h41, 8'h40, "R6 bit6 for channel2");

        // R10 irq falls when all cleared
        temp[2] = 8'h80;
        wr(8'h42, 8'h0F, "R10 clear fans");
        wr(8'h41, 8'h70, "R10 clear temps");
        check("R10 irq low when clear", 32'(irq), 32'h0);

        repeat (3) @(negedge clk);
        check("scoreboard drained", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule